// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block keeps, for one warp, a small hardware stack that lets the lanes of the warp split apart at a data-dependent branch and rejoin later. Each stack entry records where the group of lanes rejoins (the reconvergence PC), where fetch resumes for that group (the next PC), and which lanes belong to the group (the lane mask). The top entry drives the fetch PC and the execution mask seen by the rest of the pipeline.

When a branch report arrives, the block masks the taken lanes with the lanes now running. If every running lane goes one way, only the top entry's resume PC changes. If the lanes split, the top entry is turned into the rejoin point, and two new entries are pushed, one per path, with the more populated path on top. When the executing PC reaches the top entry's reconvergence PC, that entry is discarded and the group below resumes. A launch input re-initialises the stack for a new warp. Finding the rejoin points is left to the compiler, and the rejoin PC arrives with each branch report.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one base entry: `fetch_pc` equals the START_PC parameter, `lane_mask` is all ones (bit i is lane i), and both `overflow` and `underflow` are low.
- R2: `fetch_pc` and `lane_mask` always show the resume PC and lane mask of the top entry; an event sampled at one rising edge is visible on them right after that edge, and `lane_mask` is never zero.
- R3: A splitting branch (taken lanes `br_taken_mask & lane_mask` neither zero nor equal to `lane_mask`) rewrites the top entry's resume PC to `br_join_pc` and pushes two entries that both carry `br_join_pc`: the taken path with mask `br_taken_mask & lane_mask` and resume PC `br_taken_pc`, and the fall-through path with mask `lane_mask & ~br_taken_mask` and resume PC `br_fall_pc`.
- R4: Of the two pushed paths, the one with more active lanes goes on top; when the counts are equal the taken path goes on top.
- R5: A uniform branch pushes nothing: if every active lane is taken the top resume PC becomes `br_taken_pc`, and if no active lane is taken it becomes `br_fall_pc`.
- R6: When `pc_valid` is high, no branch or launch is reported, and `exec_pc` equals the top entry's reconvergence PC with more than one entry present, the top entry is popped and the entry below becomes the top.
- R7: A `pc_valid` report whose `exec_pc` differs from the top entry's reconvergence PC leaves the stack and the outputs unchanged.
- R8: A splitting branch that would exceed DEPTH entries leaves the stack unchanged and raises `overflow` for exactly one cycle.
- R9: The base entry's reconvergence PC is the null value, all ones; an `exec_pc` equal to it while only the base entry remains raises `underflow` for exactly one cycle and leaves the stack unchanged.
- R10: `launch` has priority over any branch or PC report and restores a single base entry with resume PC `launch_pc` and all lanes active, whose reconvergence PC is null.
- R11: When a branch and a PC report arrive in the same cycle, only the branch is acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Re-initialise the stack for a new warp |
| launch_pc | input | PC_W | Kernel start PC used on launch |
| br_valid | input | 1 | A branch outcome is reported this cycle |
| br_taken_mask | input | LANES | Lanes whose condition is true |
| br_taken_pc | input | PC_W | Target of the taken path |
| br_fall_pc | input | PC_W | Target of the fall-through path |
| br_join_pc | input | PC_W | Reconvergence PC of the branch |
| pc_valid | input | 1 | `exec_pc` carries the PC the warp is executing |
| exec_pc | input | PC_W | Executing PC, compared with the top reconvergence PC |
| fetch_pc | output | PC_W | Resume PC of the top entry |
| lane_mask | output | LANES | Lane mask of the top entry |
| overflow | output | 1 | One-cycle pulse: a split was refused for lack of room |
| underflow | output | 1 | One-cycle pulse: a pop was requested at the base entry |

## Verification
The stack is driven through a nested if/else pattern where both splits have equal lane counts, so the taken path must surface first, and through a split where the fall-through side has three lanes against one, which separates count-based ordering from a fixed order. Uniform branches in both directions, non-matching PCs and a branch coinciding with a matching PC show that only real splits and real reconvergence points change depth. A split refused at a full stack, a pop at the base entry through the null PC, and a launch over a deep stack cover the boundaries, with the flag pulses checked to fall again one cycle later.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;

    // Classification of a reported branch against the running lanes
    typedef enum logic [1:0] {
        BR_NONE      = 2'd0,
        BR_ALL_TAKEN = 2'd1,
        BR_ALL_FALL  = 2'd2,
        BR_SPLIT     = 2'd3
    } br_kind_e;

endpackage

// File: rtl/simt_lane_count.sv
module simt_lane_count #(
    parameter int LANES = 8,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] mask,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < LANES; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

endmodule

// File: rtl/simt_path_order.sv
module simt_path_order
    import simt_stk_pkg::*;
#(
    parameter int LANES = 8,
    parameter int PC_W  = 16
) (
    input  logic [LANES-1:0] active_mask,
    input  logic [LANES-1:0] taken_mask,
    input  logic [PC_W-1:0]  taken_pc,
    input  logic [PC_W-1:0]  fall_pc,
    output br_kind_e         kind,
    output logic [PC_W-1:0]  hi_pc,
    output logic [LANES-1:0] hi_mask,
    output logic [PC_W-1:0]  lo_pc,
    output logic [LANES-1:0] lo_mask
);

    localparam int CNT_W = $clog2(LANES + 1);

    logic [LANES-1:0] take_m;
    logic [LANES-1:0] fall_m;
    logic [CNT_W-1:0] take_n;
    logic [CNT_W-1:0] fall_n;
    logic             take_first;

    assign take_m = taken_mask & active_mask;
    assign fall_m = active_mask & ~taken_mask;

    simt_lane_count #(.LANES(LANES)) u_take_cnt (.mask(take_m), .count(take_n));
    simt_lane_count #(.LANES(LANES)) u_fall_cnt (.mask(fall_m), .count(fall_n));

    // ties favour the taken path
    assign take_first = (take_n >= fall_n);

    always_comb begin
        if (take_m == '0)               kind = BR_ALL_FALL;
        else if (take_m == active_mask) kind = BR_ALL_TAKEN;
        else                            kind = BR_SPLIT;
        hi_pc   = take_first ? taken_pc : fall_pc;
        hi_mask = take_first ? take_m   : fall_m;
        lo_pc   = take_first ? fall_pc  : taken_pc;
        lo_mask = take_first ? fall_m   : take_m;
    end

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stk_pkg::*;
#(
    parameter int              LANES    = 8,
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] START_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken_mask,
    input  logic [PC_W-1:0]  br_taken_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_join_pc,
    input  logic             pc_valid,
    input  logic [PC_W-1:0]  exec_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] lane_mask,
    output logic             overflow,
    output logic             underflow
);

    localparam int              CNT_W   = $clog2(DEPTH + 1);
    localparam int              IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PC_W-1:0] NULL_PC = {PC_W{1'b1}};

    typedef struct packed {
        logic [PC_W-1:0]  join_pc;
        logic [PC_W-1:0]  resume_pc;
        logic [LANES-1:0] mask;
    } frame_t;

    typedef struct packed {
        frame_t [DEPTH-1:0] frm;
        logic [CNT_W-1:0]   cnt;
        logic               ovf;
        logic               unf;
    } stk_t;

    stk_t s_d, s_q;

    logic [IDX_W-1:0] top_idx, up1_idx, up2_idx, below_idx;
    frame_t           top_f;
    logic             has_room;
    logic             at_join;

    br_kind_e         kind;
    logic [PC_W-1:0]  hi_pc, lo_pc;
    logic [LANES-1:0] hi_mask, lo_mask;

    assign top_idx   = IDX_W'(s_q.cnt - CNT_W'(1));
    assign up1_idx   = IDX_W'(s_q.cnt);
    assign up2_idx   = IDX_W'(s_q.cnt + CNT_W'(1));
    assign below_idx = top_idx - IDX_W'(1);
    assign top_f     = s_q.frm[top_idx];
    assign has_room  = (s_q.cnt <= CNT_W'(DEPTH - 2));
    assign at_join   = pc_valid && (exec_pc == top_f.join_pc);

    simt_path_order #(.LANES(LANES), .PC_W(PC_W)) u_order (
        .active_mask (top_f.mask),
        .taken_mask  (br_taken_mask),
        .taken_pc    (br_taken_pc),
        .fall_pc     (br_fall_pc),
        .kind        (kind),
        .hi_pc       (hi_pc),
        .hi_mask     (hi_mask),
        .lo_pc       (lo_pc),
        .lo_mask     (lo_mask)
    );

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        s_d.unf = 1'b0;
        if (launch) begin
            s_d.frm    = '0;
            s_d.frm[0] = '{join_pc: NULL_PC, resume_pc: launch_pc, mask: {LANES{1'b1}}};
            s_d.cnt    = CNT_W'(1);
        end else if (br_valid) begin
            case (kind)
                BR_ALL_TAKEN: s_d.frm[top_idx].resume_pc = br_taken_pc;
                BR_ALL_FALL:  s_d.frm[top_idx].resume_pc = br_fall_pc;
                BR_SPLIT: begin
                    if (has_room) begin
                        s_d.frm[top_idx].resume_pc = br_join_pc;
                        s_d.frm[up1_idx] = '{join_pc: br_join_pc, resume_pc: lo_pc, mask: lo_mask};
                        s_d.frm[up2_idx] = '{join_pc: br_join_pc, resume_pc: hi_pc, mask: hi_mask};
                        s_d.cnt = s_q.cnt + CNT_W'(2);
                    end else begin
                        s_d.ovf = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (at_join) begin
            if (s_q.cnt == CNT_W'(1)) s_d.unf = 1'b1;
            else                      s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.cnt    <= CNT_W'(1);
            s_q.frm[0] <= '{join_pc: NULL_PC, resume_pc: START_PC, mask: {LANES{1'b1}}};
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_pc  = top_f.resume_pc;
    assign lane_mask = top_f.mask;
    assign overflow  = s_q.ovf;
    assign underflow = s_q.unf;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt <= CNT_W'(DEPTH)) && (s_q.cnt != '0));

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |-> (s_q.cnt == $past(s_q.cnt)) && (fetch_pc == $past(fetch_pc)));

    // R9
    unf_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.unf |-> (s_q.cnt == CNT_W'(1)) && (s_q.frm[0].join_pc == NULL_PC));

    // R3
    split_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && br_valid && kind == BR_SPLIT && has_room)
        |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(2)) && (s_q.frm[below_idx].join_pc == $past(br_join_pc)));

    // R4
    hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && br_valid && kind == BR_SPLIT && has_room)
        |=> ($countones(lane_mask) >= $countones(s_q.frm[below_idx].mask)));

    // R6
    pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!launch && !br_valid && at_join && s_q.cnt > CNT_W'(1))
        |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));

    // R2
    mask_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_mask != '0);

endmodule

// File: tb/simt_reconv_stack_bench.sv
`timescale 1ns/1ps
module simt_reconv_stack_bench;

    localparam int LANES = 4;
    localparam int PC_W  = 8;
    localparam int DEPTH = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             launch = 1'b0;
    logic [PC_W-1:0]  launch_pc = '0;
    logic             br_valid = 1'b0;
    logic [LANES-1:0] br_taken_mask = '0;
    logic [PC_W-1:0]  br_taken_pc = '0, br_fall_pc = '0, br_join_pc = '0;
    logic             pc_valid = 1'b0;
    logic [PC_W-1:0]  exec_pc = '0;
    logic [PC_W-1:0]  fetch_pc;
    logic [LANES-1:0] lane_mask;
    logic             overflow, underflow;

    always #5 clk = ~clk;

    simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(8'h10)) u_simt_reconv_stack (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
        .br_valid(br_valid), .br_taken_mask(br_taken_mask), .br_taken_pc(br_taken_pc),
        .br_fall_pc(br_fall_pc), .br_join_pc(br_join_pc), .pc_valid(pc_valid), .exec_pc(exec_pc),
        .fetch_pc(fetch_pc), .lane_mask(lane_mask), .overflow(overflow), .underflow(underflow)
    );

    typedef struct {
        logic [PC_W-1:0]  pc;
        logic [LANES-1:0] mask;
        logic             ovf;
        logic             unf;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // monitor: one expectation per cycle, compared away from the rising edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (fetch_pc !== e.pc || lane_mask !== e.mask || overflow !== e.ovf || underflow !== e.unf) begin
                n_bad++;
                $display("FAIL %s: got pc=%h mask=%b ovf=%b unf=%b, expected pc=%h mask=%b ovf=%b unf=%b",
                         e.tag, fetch_pc, lane_mask, overflow, underflow, e.pc, e.mask, e.ovf, e.unf);
            end
        end
    end

    task automatic expect_out(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m,
                              input logic ov, input logic un, input string tag);
        exp_t e;
        e.pc = pc; e.mask = m; e.ovf = ov; e.unf = un; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic finish_step(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m,
                               input logic ov, input logic un, input string tag);
        @(posedge clk);
        #1;
        launch = 1'b0; br_valid = 1'b0; pc_valid = 1'b0;
        expect_out(pc, m, ov, un, tag);
    endtask

    task automatic do_branch(input logic [LANES-1:0] tm, input logic [PC_W-1:0] tpc,
                             input logic [PC_W-1:0] fpc, input logic [PC_W-1:0] jpc,
                             input logic [PC_W-1:0] pc, input logic [LANES-1:0] m,
                             input logic ov, input string tag);
        @(negedge clk);
        br_valid = 1'b1; br_taken_mask = tm; br_taken_pc = tpc; br_fall_pc = fpc; br_join_pc = jpc;
        finish_step(pc, m, ov, 1'b0, tag);
    endtask

    task automatic do_pc(input logic [PC_W-1:0] xpc, input logic [PC_W-1:0] pc,
                         input logic [LANES-1:0] m, input logic un, input string tag);
        @(negedge clk);
        pc_valid = 1'b1; exec_pc = xpc;
        finish_step(pc, m, 1'b0, un, tag);
    endtask

    task automatic do_idle(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m, input string tag);
        @(negedge clk);
        finish_step(pc, m, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_out(8'h10, 4'b1111, 1'b0, 1'b0, "R1 reset state");

        // outer if/else split, 2 vs 2 lanes: taken (lanes 0,2) on top
        do_branch(4'b0101, 8'h20, 8'h40, 8'h50, 8'h20, 4'b0101, 1'b0, "R3 R4 outer split tie");
        // inner split 1 vs 1: taken lane 0 on top
        do_branch(4'b0001, 8'h24, 8'h28, 8'h2C, 8'h24, 4'b0001, 1'b0, "R3 R4 inner split tie");
        // reach inner join: else side (lane 2) resumes
        do_pc(8'h2C, 8'h28, 4'b0100, 1'b0, "R6 pop to fall path");
        do_pc(8'h30, 8'h28, 4'b0100, 1'b0, "R7 non-matching pc");
        do_pc(8'h2C, 8'h2C, 4'b0101, 1'b0, "R6 R3 pop to rewritten join");
        // uniform branches on lanes 0,2
        do_branch(4'b1111, 8'h34, 8'h3C, 8'h50, 8'h34, 4'b0101, 1'b0, "R5 all taken");
        do_branch(4'b1010, 8'h36, 8'h38, 8'h50, 8'h38, 4'b0101, 1'b0, "R5 none taken");
        // branch and join pc together: branch wins (uniform, no pop)
        @(negedge clk);
        br_valid = 1'b1; br_taken_mask = 4'b1111; br_taken_pc = 8'h3A; br_fall_pc = 8'h3E; br_join_pc = 8'h50;
        pc_valid = 1'b1; exec_pc = 8'h50;
        finish_step(8'h3A, 4'b0101, 1'b0, 1'b0, "R11 branch over pop");
        do_pc(8'h50, 8'h40, 4'b1010, 1'b0, "R6 pop to outer else");
        do_pc(8'h50, 8'h50, 4'b1111, 1'b0, "R6 pop to base");
        // null pc at base
        do_pc(8'hFF, 8'h50, 4'b1111, 1'b1, "R9 underflow at base");
        do_idle(8'h50, 4'b1111, "R9 underflow pulse ends");
        // 1 vs 3 lanes: fall path on top
        do_branch(4'b0001, 8'h60, 8'h70, 8'h80, 8'h70, 4'b1110, 1'b0, "R4 larger fall path first");
        // 2 vs 1 from lanes 1..3: taken on top, depth 5
        do_branch(4'b0110, 8'h90, 8'hA0, 8'hB0, 8'h90, 4'b0110, 1'b0, "R4 larger taken path first");
        // would need 7 > 6
        do_branch(4'b0010, 8'hC0, 8'hD0, 8'hE0, 8'h90, 4'b0110, 1'b1, "R8 overflow refused");
        do_idle(8'h90, 4'b0110, "R8 overflow pulse ends");
        do_pc(8'hB0, 8'hA0, 4'b1000, 1'b0, "R8 R6 stack intact after overflow");
        // launch over a deep stack
        @(negedge clk);
        launch = 1'b1; launch_pc = 8'h05;
        br_valid = 1'b1; br_taken_mask = 4'b1000; br_taken_pc = 8'h99; br_fall_pc = 8'h9A; br_join_pc = 8'h9B;
        finish_step(8'h05, 4'b1111, 1'b0, 1'b0, "R10 launch priority");
        do_pc(8'hB0, 8'h05, 4'b1111, 1'b0, "R10 old joins gone");
        do_pc(8'hFF, 8'h05, 4'b1111, 1'b1, "R10 R9 null join on new base");
        do_idle(8'h05, 4'b1111, "R2 steady outputs");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule